// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block is the execute stage for the register-to-register arithmetic and logic instructions of a small 16-bit load/store processor. It decodes a 16-bit instruction word, presents the two source register indices to the register file, and combines the two values read back into a result. The result leaves the block together with a destination index and a write enable. The supported operations are addition, bitwise AND and bitwise complement. For addition and AND, the second operand is either a register or a short signed constant taken from the instruction.

The block also owns the three-bit sign flag register: negative, zero and strictly positive. This register is refreshed from whatever value is being written back to the register file. That value is either the operate result or a value supplied by the load path through its own input and qualifier. The controller gates every refresh with a flag-load enable.

Top module: `operate_unit`

## Requirements
- R1: With opcode `instr[15:12]` = 4'b0001 and `instr[5]` = 0, `result` is `sr1_data + sr2_data` modulo 2^16.
- R2: With opcode 4'b0101, `result` is the bitwise AND of `sr1_data` and the second operand, which is selected by `instr[5]` as for R1 and R3.
- R3: When `instr[5]` = 1 for opcodes 0001 or 0101, the second operand is `instr[4:0]` sign-extended to 16 bits, and `sr2_data` has no effect.
- R4: With opcode 4'b1001, `result` is `~sr1_data`, and `instr[5:0]` has no effect. `result` is combinational, so the source and destination may be the same register.
- R5: `dst_idx` = `instr[11:9]`, `sr1_idx` = `instr[8:6]` and `sr2_idx` = `instr[2:0]`, all combinational.
- R6: `wr_en` is 1 only when `instr_valid` is 1 and the opcode is 0001, 0101 or 1001. Any other opcode, or `instr_valid` = 0, gives `wr_en` = 0.
- R7: `cc` is encoded {N,Z,P} (bit 2 negative, bit 1 zero, bit 0 positive). It always has exactly one bit set, and reset (`rst_n` = 0) sets it to 3'b010.
- R8: At a rising clock edge with `ld_cc` = 1 and `wr_en` = 1, `cc` takes the flags of `result`: N if bit 15 is set, Z if the value is zero, P otherwise.
- R9: At a rising clock edge with `ld_cc` = 1, `wr_en` = 0 and `ld_val_en` = 1, `cc` takes the flags of `ld_val`. If `ld_cc` = 1 with neither source present, `cc` is unchanged.
- R10: When `ld_cc` = 0, `cc` holds its value whatever the other inputs are.
- R11: When `wr_en` and `ld_val_en` are both 1, the operate result has priority over `ld_val` for the flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| sr1_data | input | XLEN | Value read at `sr1_idx` |
| sr2_data | input | XLEN | Value read at `sr2_idx` |
| ld_cc | input | 1 | Flag-load enable from the controller |
| ld_val | input | XLEN | Write-back value from the load path |
| ld_val_en | input | 1 | `ld_val` is being written back this cycle |
| sr1_idx | output | 3 | First source register index |
| sr2_idx | output | 3 | Second source register index |
| dst_idx | output | 3 | Destination register index |
| result | output | XLEN | Operate result |
| wr_en | output | 1 | Register write enable |
| cc | output | 3 | Flags {N,Z,P} |

## Verification
The bench builds the block at its default XLEN of 16. At that width the 16-bit wrap-around of an addition, the sign bit at position 15 and both ends of the five-bit constant (-16 and +15) can all be reached with directed words. A scoreboard model checks the flag register across sequences that mix operate writes, load-path writes, enables held low and unsupported opcodes. Each case is set up so that a wrong priority or a missed hold leaves a visibly different flag value.

// File: rtl/operate_unit.sv
module operate_unit #(
  parameter int XLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     instr,
  input  logic            instr_valid,
  input  logic [XLEN-1:0] sr1_data,
  input  logic [XLEN-1:0] sr2_data,
  input  logic            ld_cc,
  input  logic [XLEN-1:0] ld_val,
  input  logic            ld_val_en,
  output logic [2:0]      sr1_idx,
  output logic [2:0]      sr2_idx,
  output logic [2:0]      dst_idx,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic [2:0]      cc
);
  localparam int IMM_W = 5;
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;

  logic [3:0]      opc;
  logic            is_add, is_and, is_not;
  logic [XLEN-1:0] opnd_b, cc_src;
  logic [2:0]      cc_next;

  assign opc     = instr[15:12];
  assign is_add  = (opc == OP_ADD);
  assign is_and  = (opc == OP_AND);
  assign is_not  = (opc == OP_NOT);
  assign dst_idx = instr[11:9];
  assign sr1_idx = instr[8:6];
  assign sr2_idx = instr[2:0];

  assign opnd_b = instr[5] ? {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]} : sr2_data;

  always_comb begin
    if (is_add)      result = sr1_data + opnd_b;
    else if (is_and) result = sr1_data & opnd_b;
    else             result = ~sr1_data;
  end

  assign wr_en = instr_valid & (is_add | is_and | is_not);

  assign cc_src  = wr_en ? result : ld_val;
  assign cc_next = {cc_src[XLEN-1], (cc_src == '0), ~cc_src[XLEN-1] & (cc_src != '0)};

  always_ff @(posedge clk) begin
    if (!rst_n)                           cc <= 3'b010;
    else if (ld_cc && (wr_en || ld_val_en)) cc <= cc_next;
  end

  a_r7_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1);

  a_r10_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cc |=> $stable(cc));

  a_r8_cc_from_result: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cc && wr_en) |=> (cc[1] == ($past(result) == '0)) && (cc[2] == $past(result[XLEN-1])));

  a_r6_no_write_other_op: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] != 4'b0001 && instr[15:12] != 4'b0101 && instr[15:12] != 4'b1001) |-> !wr_en);

  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cc && !wr_en && !ld_val_en) |=> $stable(cc));
endmodule

// File: tb/operate_unit_bench.sv
module operate_unit_bench;
  localparam int XLEN = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     instr = '0;
  logic            instr_valid = 1'b0;
  logic [XLEN-1:0] sr1_data = '0, sr2_data = '0, ld_val = '0;
  logic            ld_cc = 1'b0, ld_val_en = 1'b0;
  logic [2:0]      sr1_idx, sr2_idx, dst_idx, cc;
  logic [XLEN-1:0] result;
  logic            wr_en;

  always #10 clk = ~clk;

  operate_unit #(.XLEN(XLEN)) u_operate_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
    .sr1_data(sr1_data), .sr2_data(sr2_data), .ld_cc(ld_cc), .ld_val(ld_val),
    .ld_val_en(ld_val_en), .sr1_idx(sr1_idx), .sr2_idx(sr2_idx),
    .dst_idx(dst_idx), .result(result), .wr_en(wr_en), .cc(cc));

  typedef struct {
    logic [XLEN-1:0] res;
    logic            wr;
    logic [2:0]      dst, s1, s2, ccv;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  logic [2:0] m_cc = 3'b010;
  bit   done = 1'b0;

  function automatic logic [2:0] flags(input logic [XLEN-1:0] v);
    if (v[XLEN-1])   return 3'b100;
    else if (v == 0) return 3'b010;
    else             return 3'b001;
  endfunction

  function automatic logic [XLEN-1:0] model(input logic [15:0] i,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN-1:0] bb;
    bb = i[5] ? XLEN'($signed(i[4:0])) : b;
    case (i[15:12])
      4'b0001: return a + bb;
      4'b0101: return a & bb;
      default: return ~a;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] i, input logic v,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
      input logic lc, input logic [XLEN-1:0] lv, input logic lve);
    exp_t e;
    @(negedge clk);
    instr = i; instr_valid = v; sr1_data = a; sr2_data = b;
    ld_cc = lc; ld_val = lv; ld_val_en = lve;
    e.wr  = v && (i[15:12] == 4'b0001 || i[15:12] == 4'b0101 || i[15:12] == 4'b1001);
    e.res = model(i, a, b);
    e.dst = i[11:9]; e.s1 = i[8:6]; e.s2 = i[2:0];
    if (lc && e.wr)       m_cc = flags(e.res);
    else if (lc && lve)   m_cc = flags(lv);
    e.ccv = m_cc;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "wr_en", 32'(wr_en), 32'(e.wr));
        if (e.wr) chk(e.tag, "result", 32'(result), 32'(e.res));
        chk("R5", "dst_idx", 32'(dst_idx), 32'(e.dst));
        chk("R5", "sr1_idx", 32'(sr1_idx), 32'(e.s1));
        chk("R5", "sr2_idx", 32'(sr2_idx), 32'(e.s2));
        chk(e.tag, "cc", 32'(cc), 32'(e.ccv));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "reset cc", 32'(cc), 32'h2);
    // R1 register add, positive
    apply("R1", {4'b0001, 3'd3, 3'd1, 3'b000, 3'd2}, 1, 16'd100, 16'd23, 1, 16'h0, 0);
    // R1 wrap to zero
    apply("R1", {4'b0001, 3'd7, 3'd7, 3'b000, 3'd7}, 1, 16'hFFFF, 16'h0001, 1, 16'h0, 0);
    // R3 immediate -16, sr2 ignored
    apply("R3", {4'b0001, 3'd2, 3'd4, 1'b1, 5'b10000}, 1, 16'd5, 16'h7777, 1, 16'h0, 0);
    // R3 immediate +15
    apply("R3", {4'b0001, 3'd0, 3'd0, 1'b1, 5'b01111}, 1, 16'd1, 16'hAAAA, 1, 16'h0, 0);
    // R2 register and
    apply("R2", {4'b0101, 3'd5, 3'd6, 3'b000, 3'd1}, 1, 16'hF0F0, 16'h3C3C, 1, 16'h0, 0);
    // R2 immediate and with -2 mask, sign-extended
    apply("R2", {4'b0101, 3'd1, 3'd2, 1'b1, 5'b11110}, 1, 16'h8001, 16'h0000, 1, 16'h0, 0);
    // R2 immediate and with 0 clears
    apply("R2", {4'b0101, 3'd1, 3'd1, 1'b1, 5'b00000}, 1, 16'h1234, 16'hFFFF, 1, 16'h0, 0);
    // R4 not, same register, junk low bits
    apply("R4", {4'b1001, 3'd4, 3'd4, 6'b101010}, 1, 16'h00FF, 16'h1111, 1, 16'h0, 0);
    apply("R4", {4'b1001, 3'd4, 3'd4, 6'b111111}, 1, 16'hFFFF, 16'h2222, 1, 16'h0, 0);
    // R6 unsupported opcode, ld_cc high, no load: no write, cc held
    apply("R6", {4'b0010, 3'd1, 3'd2, 6'b000011}, 1, 16'h8000, 16'h8000, 1, 16'h0, 0);
    // R6 valid low
    apply("R6", {4'b0001, 3'd1, 3'd2, 6'b000011}, 0, 16'h0001, 16'h0001, 1, 16'h0, 0);
    // R10 ld_cc low, operate negative result does not move cc
    apply("R10", {4'b0001, 3'd1, 3'd2, 6'b000011}, 1, 16'h8000, 16'h0001, 0, 16'h0, 0);
    // R9 load path negative
    apply("R9", {4'b0000, 3'd1, 3'd2, 6'b0}, 1, 16'h0, 16'h0, 1, 16'h8000, 1);
    // R9 load path positive
    apply("R9", {4'b1111, 3'd1, 3'd2, 6'b0}, 0, 16'h0, 16'h0, 1, 16'h0042, 1);
    // R10 load without ld_cc
    apply("R10", {4'b0000, 3'd0, 3'd0, 6'b0}, 0, 16'h0, 16'h0, 0, 16'h0000, 1);
    // R11 both present: operate wins (zero vs negative load)
    apply("R11", {4'b0101, 3'd6, 3'd3, 1'b1, 5'b00000}, 1, 16'hFFFF, 16'h0, 1, 16'h8000, 1);
    apply("R11", {4'b0001, 3'd6, 3'd3, 3'b000, 3'd5}, 1, 16'h0003, 16'h0004, 1, 16'h0000, 1);
    // R8 negative result from add
    apply("R8", {4'b0001, 3'd2, 3'd0, 3'b000, 3'd1}, 1, 16'h7FFF, 16'h0001, 1, 16'h0, 0);
    repeat (3) @(posedge clk);
    #5;
    chk("R8", "queue drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule